// File: doc/BRIEF.md
# Multi-Strobe Serial Converter Input Register

This block is the digital front end of a 12-bit serial-input converter. A single serial data pin feeds a shift register, most significant bit first. Any one of four strobe pins clocks in a bit. Three strobes act on a rising edge and one acts on a falling edge. A strobe edge counts only while the other three strobes rest at their idle levels, so several strobe sources can share the pin set without false shifts. A holding register drives the converter code. It copies the shift register while two active-low load pins are both low, and an active-low clear forces it to zero at once.

All pins are asynchronous to the fast system clock. They pass through two-flop synchronizers, and strobe edges are found by comparing the current synchronized sample with the previous one. The serial pin goes through the same synchronizer depth as the strobes, so the bit that is sampled lines up with the edge that takes it. The clear acts immediately and is released synchronously. While the clear is held it overrides a load.

Top module: `serial_dac_frontend`

## Requirements
- R1: The shift register is 12 bits wide and shifts left. The newest serial bit enters at bit 0, so after 12 shifts the first bit sent sits at bit 11.
- R2: A rising edge on strobe_p1, strobe_p2 or strobe_p4 shifts in one bit while the other three strobes are idle.
- R3: A falling edge on strobe_n3 shifts in one bit while the other three strobes are idle.
- R4: The idle level is low for strobe_p1, strobe_p2 and strobe_p4 and high for strobe_n3. An active edge on one strobe while any other strobe is away from its idle level leaves the shift register unchanged.
- R5: The inactive edge of each strobe (falling on p1/p2/p4, rising on n3) never shifts.
- R6: The holding register copies the shift register while load_a_n and load_b_n are both low. With either load pin high it keeps its value.
- R7: clear_n low forces the holding register to zero without waiting for a clock edge. It leaves the shift register unchanged.
- R8: While clear_n is low the holding register stays zero even with both load pins low. After clear_n rises, a pending load copies the shift register again within a few clock cycles.
- R9: After rst_n both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_in | input | 1 | Serial data, MSB first |
| strobe_p1 | input | 1 | Strobe, rising edge active, idle low |
| strobe_p2 | input | 1 | Strobe, rising edge active, idle low |
| strobe_n3 | input | 1 | Strobe, falling edge active, idle high |
| strobe_p4 | input | 1 | Strobe, rising edge active, idle low |
| load_a_n | input | 1 | Load enable A, active low |
| load_b_n | input | 1 | Load enable B, active low |
| clear_n | input | 1 | Clear of the holding register, active low |
| hold_q | output | 12 | Holding register, the converter code |
| shift_q | output | 12 | Shift register contents (debug) |

## Verification
The bench sends several words through each strobe in turn and checks the shift register after every leading and trailing edge. A design that shifted on the wrong polarity, or on both edges, would gain extra bits and break the word. Each strobe is also held away from idle while another strobe fires. A design that did not qualify the edges would accept these bits. The holding register is tested with each load pin low on its own, with a clear that overlaps an active load, and at the clear's release. These tests catch a load that only needs one pin, a clear that waits for a clock, or a clear that also wipes the shift register.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    // Strobe ordering: bit0 = p1, bit1 = p2, bit2 = n3, bit3 = p4
    localparam int NUM_STROBES = 4;
    localparam logic [NUM_STROBES-1:0] STROBE_IDLE = 4'b0100;
    localparam int NUM_LOADS = 2;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dacfe_clr_sync.sv
module dacfe_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_n,
    output logic clr_release
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              arst_n;

    assign arst_n = rst_n & clear_n;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign clr_release = chain_q[STAGES-1];
endmodule

// File: rtl/dacfe_strobe_qual.sv
module dacfe_strobe_qual #(
    parameter int                N    = 4,
    parameter logic [N-1:0]      IDLE = '0
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    output logic         shift_en
);
    logic [N-1:0] away;
    logic [N-1:0] qual;

    assign away = cur ^ IDLE;

    generate
        for (genvar i = 0; i < N; i++) begin : g_strobe
            logic [N-1:0] others_mask;
            logic         lead_edge;
            assign others_mask = ~(N'(1) << i);
            assign lead_edge   = (prev[i] == IDLE[i]) && (cur[i] != IDLE[i]);
            assign qual[i]     = lead_edge && ((away & others_mask) == '0);
        end
    endgenerate

    assign shift_en = |qual;
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
    import dacfe_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serial_in,
    input  logic             strobe_p1,
    input  logic             strobe_p2,
    input  logic             strobe_n3,
    input  logic             strobe_p4,
    input  logic             load_a_n,
    input  logic             load_b_n,
    input  logic             clear_n,
    output logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] shift_q
);
    localparam int PIN_W = 1 + NUM_LOADS + NUM_STROBES;
    localparam logic [PIN_W-1:0] PIN_RST = {1'b0, {NUM_LOADS{1'b1}}, STROBE_IDLE};

    typedef struct packed {
        logic [WIDTH-1:0]       shift;
        logic [NUM_STROBES-1:0] strb_prev;
    } regs_t;

    regs_t                  regs_d, regs_q;
    logic [WIDTH-1:0]       hold_d;
    logic [PIN_W-1:0]       pins_raw, pins_s;
    logic [NUM_STROBES-1:0] strb_s;
    logic [NUM_LOADS-1:0]   load_s;
    logic                   sdi_s;
    logic                   shift_en;
    logic                   clr_rel;
    logic                   hold_rst_n;

    assign pins_raw = {serial_in, load_b_n, load_a_n,
                       strobe_p4, strobe_n3, strobe_p2, strobe_p1};

    dacfe_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST)) u_pin_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    assign strb_s = pins_s[NUM_STROBES-1:0];
    assign load_s = pins_s[NUM_STROBES +: NUM_LOADS];
    assign sdi_s  = pins_s[PIN_W-1];

    dacfe_clr_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_n     (clear_n),
        .clr_release (clr_rel)
    );

    dacfe_strobe_qual #(.N(NUM_STROBES), .IDLE(STROBE_IDLE)) u_qual (
        .cur      (strb_s),
        .prev     (regs_q.strb_prev),
        .shift_en (shift_en)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.strb_prev = strb_s;
        if (shift_en) begin
            regs_d.shift = {regs_q.shift[WIDTH-2:0], sdi_s};
        end
        hold_d = hold_q;
        if (load_s == '0) begin
            hold_d = regs_q.shift;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{shift: '0, strb_prev: STROBE_IDLE};
        else        regs_q <= regs_d;
    end

    assign hold_rst_n = rst_n & clr_rel;

    always_ff @(posedge clk or negedge hold_rst_n) begin
        if (!hold_rst_n) hold_q <= '0;
        else             hold_q <= hold_d;
    end

    assign shift_q = regs_q.shift;
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_rel,
    input logic             shift_en,
    input logic             sdi_s,
    input logic [1:0]       load_s,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] hold_q
);
    assert_no_stray_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(shift_q));

    assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(sdi_s)});

    assert_load_copy_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_rel)
        (load_s == 2'b00) |=> hold_q == $past(shift_q));

    assert_load_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_rel)
        (load_s != 2'b00) |=> $stable(hold_q));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_rel |-> hold_q == '0);
endmodule

bind serial_dac_frontend dacfe_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_rel  (clr_rel),
    .shift_en (shift_en),
    .sdi_s    (sdi_s),
    .load_s   (load_s),
    .shift_q  (shift_q),
    .hold_q   (hold_q)
);

// File: tb/tb_serial_dac_frontend.sv
module tb_serial_dac_frontend;
    localparam int W = 12;
    localparam logic [3:0] IDLE = 4'b0100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sdi = 1'b0;
    logic [3:0]   stb = IDLE;
    logic         lda_n = 1'b1, ldb_n = 1'b1, clr_n = 1'b1;
    logic [W-1:0] hold_q, shift_q;
    logic [W-1:0] exp_shift = '0;
    logic [W-1:0] exp_hold  = '0;
    int           errors = 0, checks = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    serial_dac_frontend #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .serial_in(sdi),
        .strobe_p1(stb[0]), .strobe_p2(stb[1]), .strobe_n3(stb[2]), .strobe_p4(stb[3]),
        .load_a_n(lda_n), .load_b_n(ldb_n), .clear_n(clr_n),
        .hold_q(hold_q), .shift_q(shift_q)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one full strobe pulse on strobe i with data bit b
    task automatic pulse(input int i, input logic b);
        sdi = b;
        wait_cyc(3);
        stb[i] = ~IDLE[i];
        exp_shift = {exp_shift[W-2:0], b};
        wait_cyc(5);
        check((i == 2) ? "R3 lead edge" : "R2 lead edge", shift_q, exp_shift);
        stb[i] = IDLE[i];
        wait_cyc(5);
        check("R5 trailing edge", shift_q, exp_shift);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] words [4];
        words[0] = 12'hA5C; words[1] = 12'h3F0; words[2] = 12'h001; words[3] = 12'hFFF;

        wait_cyc(4);
        check("R9 reset shift", shift_q, '0);
        check("R9 reset hold", hold_q, '0);
        rst_n = 1'b1;
        wait_cyc(4);

        // R1/R2/R3: full words through each strobe
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) begin
                for (int k = W - 1; k >= 0; k--) pulse(s, words[w][k]);
                check("R1 full word", shift_q, words[w]);
            end
        end

        // R4: wrong strobe held active
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < 4; i++) begin
                if (i != j) begin
                    sdi = ~exp_shift[0];
                    wait_cyc(3);
                    stb[j] = ~IDLE[j];
                    exp_shift = {exp_shift[W-2:0], sdi};
                    wait_cyc(5);
                    check("R2 R3 blocker edge", shift_q, exp_shift);
                    sdi = ~sdi;
                    wait_cyc(3);
                    stb[i] = ~IDLE[i];
                    wait_cyc(5);
                    check("R4 blocked edge", shift_q, exp_shift);
                    stb[i] = IDLE[i];
                    wait_cyc(5);
                    stb[j] = IDLE[j];
                    wait_cyc(5);
                    check("R4 R5 release", shift_q, exp_shift);
                end
            end
        end

        // R6: load with one pin only, then both
        for (int k = W - 1; k >= 0; k--) pulse(0, words[0][k]);
        lda_n = 1'b0;
        wait_cyc(6);
        check("R6 only load_a low", hold_q, exp_hold);
        lda_n = 1'b1; ldb_n = 1'b0;
        wait_cyc(6);
        check("R6 only load_b low", hold_q, exp_hold);
        lda_n = 1'b0;
        exp_hold = exp_shift;
        wait_cyc(6);
        check("R6 both low", hold_q, exp_hold);
        lda_n = 1'b1; ldb_n = 1'b1;
        for (int k = W - 1; k >= 0; k--) pulse(1, words[1][k]);
        check("R6 hold after release", hold_q, exp_hold);

        // R7/R8: clear immediate, priority over load, release
        clr_n = 1'b0;
        #1;
        check("R7 clear immediate", hold_q, '0);
        check("R7 shift untouched", shift_q, exp_shift);
        lda_n = 1'b0; ldb_n = 1'b0;
        wait_cyc(8);
        check("R8 clear beats load", hold_q, '0);
        pulse(3, 1'b1);
        check("R8 hold zero after shift", hold_q, '0);
        clr_n = 1'b1;
        wait_cyc(6);
        check("R8 load after clear", hold_q, exp_shift);
        lda_n = 1'b1; ldb_n = 1'b1;
        wait_cyc(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule